// File: doc/BRIEF.md
# Interleaved Character-Page Scan Address Generator

This block walks a 40-column by 24-row character page in display order and produces the memory address of each cell as it goes. A display engine uses it during the memory phases that the processor leaves idle. It pulses a column strobe once for each character cell, or a row strobe to jump to the start of the next line. The block returns the byte address to fetch.

The page is not stored linearly. Lines fall into three bands of eight. Line `r` starts at `base + (r mod 8)*128 + (r div 8)*40`. Consecutive lines are therefore 128 bytes apart. Each 128-byte group holds one 40-byte line from each band, which leaves its top 8 bytes unused. Because the scan sweeps the low address bits this way, a full frame touches every one of 128 DRAM row codes. The DRAM row code is formed from the line-in-band bits and the low nibble of the address. Displaying the page therefore also refreshes the memory.

A page-select bit chooses between two 1 KB pages. It is sampled on each strobe.

Top module: `txt_scan_addr`

## Requirements
- R1: While `rst_n` is low and after its release, `cur_col` and `cur_row` are 0, `scan_addr` is 16'h0400, and `addr_valid` and `frame_wrap` are 0.
- R2: A `col_step` with `row_step` low moves to the next column of the same line. The new `scan_addr` is the previous one plus 1, and `addr_valid` is high in the cycle after the strobe edge.
- R3: A `col_step` at column 39 wraps the column to 0 and advances the line by one.
- R4: Advancing past line 23 returns to line 0. On that step `frame_wrap` is high for one cycle, together with the new address 16'h0400 (page 0).
- R5: `row_step` sets the column to 0 and advances the line. It takes priority when `col_step` is high in the same cycle.
- R6: The address of line r, column c is `base + (r mod 8)*128 + (r div 8)*40 + c`. For example, line 1 starts at 16'h0480, line 8 starts at 16'h0428, and line 0 column 39 is 16'h0427.
- R7: With `page_sel` = 0 the base is 16'h0400, and with `page_sel` = 1 it is 16'h0800. `page_sel` is sampled only on a strobe. A change with no strobe leaves `scan_addr` unchanged and `addr_valid` low.
- R8: Every valid address lies inside the selected 1 KB page. Its offset within the 128-byte group is below 120, so the unused last 8 bytes are never fetched.
- R9: `refresh_row` = {`scan_addr[9:7]`, `scan_addr[3:0]`}. One full frame of 960 column steps produces all 128 values.
- R10: `addr_valid` is high exactly in the cycles that follow a cycle with `col_step` or `row_step` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_step | input | 1 | Advance one character cell |
| row_step | input | 1 | Jump to column 0 of the next line |
| page_sel | input | 1 | Page choice, sampled with a strobe |
| scan_addr | output | 16 | Byte address of the current cell |
| addr_valid | output | 1 | Pulse: `scan_addr` updated by the last strobe |
| frame_wrap | output | 1 | Pulse: this step returned to line 0 |
| refresh_row | output | 7 | DRAM row code touched by `scan_addr` |
| cur_col | output | 6 | Current column, 0..39 |
| cur_row | output | 5 | Current line, 0..23 |

## Verification
Every registered result is due one clock after the edge that samples a strobe: `scan_addr`, `addr_valid`, `frame_wrap`, `cur_col` and `cur_row` all change on that edge. `refresh_row` follows `scan_addr` combinationally. The bench drives strobes on the falling edge, lets one rising edge pass, and samples on the next falling edge. Each check therefore sees the cell selected by that one strobe. The page-hold check waits several edges with no strobe before it compares the address.

// File: rtl/txt_scan_pkg.sv
package txt_scan_pkg;
  localparam int COLS            = 40;
  localparam int ROWS            = 24;
  localparam int LINES_PER_BAND  = 8;
  localparam int GROUP_BYTES     = 128;
  localparam int ADDR_W          = 16;
  localparam int PAGE0_BASE      = 'h0400;
  localparam int PAGE_SPAN       = 'h0400;
  localparam int REF_W           = 7;

  localparam int COL_W     = $clog2(COLS);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int COL_LAST  = COLS - 1;
  localparam int ROW_LAST  = ROWS - 1;
  localparam int GROUP_SH  = $clog2(GROUP_BYTES);
  localparam int BAND_SEL_W = $clog2(LINES_PER_BAND);
  localparam int LOW_W     = REF_W - BAND_SEL_W;
  localparam int GROUP_USED = (ROWS / LINES_PER_BAND) * COLS;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [COL_W-1:0]  col_t;
  typedef logic [ROW_W-1:0]  row_t;
  typedef logic [REF_W-1:0]  ref_t;

  // Base of the selected page.
  function automatic addr_t page_base(input logic page);
    return addr_t'(PAGE0_BASE) + (page ? addr_t'(PAGE_SPAN) : addr_t'(0));
  endfunction

  // Interleaved cell mapping: line-in-band picks the 128-byte group,
  // band picks the 40-byte slot inside it.
  function automatic addr_t cell_addr(input logic page, input row_t row, input col_t col);
    addr_t r;
    addr_t line_off;
    addr_t band_off;
    r        = addr_t'(row);
    line_off = (r % addr_t'(LINES_PER_BAND)) * addr_t'(GROUP_BYTES);
    band_off = (r / addr_t'(LINES_PER_BAND)) * addr_t'(COLS);
    return page_base(page) + line_off + band_off + addr_t'(col);
  endfunction

  // DRAM row code swept by the scan.
  function automatic ref_t refresh_code(input addr_t a);
    return {a[GROUP_SH +: BAND_SEL_W], a[LOW_W-1:0]};
  endfunction
endpackage

// File: rtl/scan_wrap_counter.sv
module scan_wrap_counter #(
  parameter int W    = 6,
  parameter int LAST = 39
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap_evt
);
  logic at_last;

  assign at_last  = (cnt == W'(LAST));
  assign wrap_evt = inc && !clr && at_last;

  always_comb begin
    if (clr)          cnt_nxt = '0;
    else if (inc)     cnt_nxt = at_last ? '0 : cnt + W'(1);
    else              cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R3/R4: the count never leaves its range
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(LAST));

  // R3/R4: an increment moves by one or wraps to zero
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt == (($past(cnt) == W'(LAST)) ? '0 : $past(cnt) + W'(1))));

  // R5: a clear always lands on zero
  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/scan_addr_reg.sv
module scan_addr_reg
  import txt_scan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  page_sel,
  input  row_t  row_nxt,
  input  col_t  col_nxt,
  input  logic  frame_evt,
  output addr_t scan_addr,
  output logic  addr_valid,
  output logic  frame_wrap
);
  addr_t addr_nxt;
  addr_t page_off;

  assign addr_nxt = cell_addr(page_sel, row_nxt, col_nxt);
  assign page_off = scan_addr - addr_t'(PAGE0_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_addr  <= cell_addr(1'b0, '0, '0);
      addr_valid <= 1'b0;
      frame_wrap <= 1'b0;
    end else begin
      addr_valid <= step;
      frame_wrap <= step && frame_evt;
      if (step) scan_addr <= addr_nxt;
    end
  end

  // R7: with no strobe the address holds
  assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(scan_addr));

  // R8: a valid address stays in the two-page window and outside the holes
  assert_no_hole_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ((page_off < addr_t'(2*PAGE_SPAN)) &&
                    (scan_addr[GROUP_SH-1:0] < GROUP_SH'(GROUP_USED))));

  // R4: the frame pulse comes with a valid address at line 0 column 0 of a page
  assert_frame_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> (addr_valid && (scan_addr[$clog2(PAGE_SPAN)-1:0] == '0)));
endmodule

// File: rtl/txt_scan_addr.sv
module txt_scan_addr
  import txt_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_step,
  input  logic              row_step,
  input  logic              page_sel,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              addr_valid,
  output logic              frame_wrap,
  output logic [REF_W-1:0]  refresh_row,
  output logic [COL_W-1:0]  cur_col,
  output logic [ROW_W-1:0]  cur_row
);
  col_t col_nxt;
  row_t row_nxt;
  logic col_wrap_evt;
  logic row_inc;
  logic row_wrap_evt;
  logic step;

  assign step    = col_step || row_step;
  assign row_inc = row_step || col_wrap_evt;

  scan_wrap_counter #(.W(COL_W), .LAST(COL_LAST)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (row_step),
    .inc      (col_step),
    .cnt      (cur_col),
    .cnt_nxt  (col_nxt),
    .wrap_evt (col_wrap_evt)
  );

  scan_wrap_counter #(.W(ROW_W), .LAST(ROW_LAST)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (1'b0),
    .inc      (row_inc),
    .cnt      (cur_row),
    .cnt_nxt  (row_nxt),
    .wrap_evt (row_wrap_evt)
  );

  scan_addr_reg u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .page_sel   (page_sel),
    .row_nxt    (row_nxt),
    .col_nxt    (col_nxt),
    .frame_evt  (row_wrap_evt),
    .scan_addr  (scan_addr),
    .addr_valid (addr_valid),
    .frame_wrap (frame_wrap)
  );

  assign refresh_row = refresh_code(scan_addr);

  // R2: a plain column step moves the in-page offset by one
  assert_col_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_step && !row_step && (cur_col != COL_W'(COL_LAST))) |=>
      (scan_addr[$clog2(PAGE_SPAN)-1:0] == $past(scan_addr[$clog2(PAGE_SPAN)-1:0]) + 1'b1));

  // R10: valid follows any strobe
  assert_valid_after_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr_valid);

  // R5: a line jump starts the new line at column 0
  assert_row_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_step |=> (cur_col == '0 && addr_valid));
endmodule

// File: tb/txt_scan_addr_tb.sv
module txt_scan_addr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        col_step = 1'b0;
  logic        row_step = 1'b0;
  logic        page_sel = 1'b0;
  logic [15:0] scan_addr;
  logic        addr_valid;
  logic        frame_wrap;
  logic [6:0]  refresh_row;
  logic [5:0]  cur_col;
  logic [4:0]  cur_row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  txt_scan_addr u_dut (
    .clk(clk), .rst_n(rst_n), .col_step(col_step), .row_step(row_step),
    .page_sel(page_sel), .scan_addr(scan_addr), .addr_valid(addr_valid),
    .frame_wrap(frame_wrap), .refresh_row(refresh_row),
    .cur_col(cur_col), .cur_row(cur_row)
  );

  // Bench model: lines are 128 apart within a band, bands are 40 apart.
  function automatic logic [15:0] model_addr(input bit pg, input int r, input int c);
    int band;
    int line;
    band = r / 8;
    line = r - band * 8;
    return 16'((pg ? 'h800 : 'h400) + (line << 7) + band * 40 + c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // op: 0 column step, 1 line step, 2 both
  task automatic do_step(input int op, input bit pg);
    @(negedge clk);
    col_step = (op != 1);
    row_step = (op != 0);
    page_sel = pg;
    @(negedge clk);
    col_step = 1'b0;
    row_step = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    col_step = 1'b0;
    row_step = 1'b0;
    page_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // {op[1:0], page, row[4:0], col[5:0], addr[15:0]}
  localparam logic [29:0] VEC [13] = '{
    {2'd0, 1'b0, 5'd0, 6'd1, 16'h0401},
    {2'd0, 1'b0, 5'd0, 6'd2, 16'h0402},
    {2'd1, 1'b0, 5'd1, 6'd0, 16'h0480},
    {2'd0, 1'b1, 5'd1, 6'd1, 16'h0881},
    {2'd2, 1'b1, 5'd2, 6'd0, 16'h0900},
    {2'd1, 1'b0, 5'd3, 6'd0, 16'h0580},
    {2'd1, 1'b0, 5'd4, 6'd0, 16'h0600},
    {2'd1, 1'b0, 5'd5, 6'd0, 16'h0680},
    {2'd1, 1'b0, 5'd6, 6'd0, 16'h0700},
    {2'd1, 1'b0, 5'd7, 6'd0, 16'h0780},
    {2'd1, 1'b0, 5'd8, 6'd0, 16'h0428},
    {2'd1, 1'b1, 5'd9, 6'd0, 16'h08A8},
    {2'd0, 1'b0, 5'd9, 6'd1, 16'h04A9}
  };

  initial begin
    bit [127:0] seen;
    int r;
    int c;
    int wraps;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", 32'(scan_addr), 32'h0400);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 col", 32'(cur_col), 0);
    chk("R1 row", 32'(cur_row), 0);
    chk("R1 addr", 32'(scan_addr), 32'h0400);
    chk("R1 valid", 32'(addr_valid), 0);
    chk("R1 wrap", 32'(frame_wrap), 0);

    // Vector table: R2 R5 R6 R7
    for (int i = 0; i < 13; i++) begin
      do_step(int'(VEC[i][29:28]), VEC[i][27]);
      chk("R6 addr vector", 32'(scan_addr), 32'(VEC[i][15:0]));
      chk("R5 row vector", 32'(cur_row), 32'(VEC[i][26:22]));
      chk("R2 col vector", 32'(cur_col), 32'(VEC[i][21:16]));
      chk("R10 valid after strobe", 32'(addr_valid), 1);
      @(negedge clk);
      chk("R10 valid drops", 32'(addr_valid), 0);
    end

    // R7: page change without a strobe has no effect
    page_sel = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 hold addr", 32'(scan_addr), 32'h04A9);
    chk("R7 no valid", 32'(addr_valid), 0);

    // R3: end-of-line wrap
    do_reset();
    for (int i = 0; i < 39; i++) do_step(0, 1'b0);
    chk("R6 line0 col39", 32'(scan_addr), 32'h0427);
    do_step(0, 1'b0);
    chk("R3 wrap col", 32'(cur_col), 0);
    chk("R3 wrap row", 32'(cur_row), 1);
    chk("R3 wrap addr", 32'(scan_addr), 32'h0480);

    // Full frame: R4 R8 R9
    do_reset();
    seen = '0;
    seen[refresh_row] = 1'b1;
    r = 0;
    c = 0;
    wraps = 0;
    for (int i = 0; i < 960; i++) begin
      do_step(0, 1'b0);
      c = c + 1;
      if (c == 40) begin c = 0; r = r + 1; end
      if (r == 24) r = 0;
      if (scan_addr !== model_addr(1'b0, r, c))
        chk("R8 frame addr", 32'(scan_addr), 32'(model_addr(1'b0, r, c)));
      if (scan_addr[6:0] >= 7'd120)
        chk("R8 hole fetched", 32'(scan_addr), 0);
      if (frame_wrap) wraps++;
      if (frame_wrap !== ((r == 0) && (c == 0)))
        chk("R4 wrap pulse", 32'(frame_wrap), 32'((r == 0) && (c == 0)));
      if (refresh_row !== {scan_addr[9:7], scan_addr[3:0]})
        chk("R9 refresh code", 32'(refresh_row), 32'({scan_addr[9:7], scan_addr[3:0]}));
      seen[refresh_row] = 1'b1;
      if (i == 958) chk("R6 last cell", 32'(scan_addr), 32'h07F7);
    end
    chk("R4 frame end addr", 32'(scan_addr), 32'h0400);
    chk("R4 frame end row", 32'(cur_row), 0);
    chk("R4 one wrap", 32'(wraps), 1);
    chk("R9 all refresh rows", 32'($countones(seen)), 128);
    @(negedge clk);
    chk("R4 wrap is a pulse", 32'(frame_wrap), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule